// File: doc/BRIEF.md
# Seconds Time Counter with Alarm

This block keeps wall-clock time as one wide binary counter that advances once per cycle of a slow timekeeping clock (32.768 kHz in the intended use). The upper part of the counter holds whole seconds and the lower 15 bits hold the sub-second fraction, so the seconds field steps once every 32768 cycles. A comparator watches the seconds field against a programmable alarm value and raises a sticky flag, which can drive an interrupt output.

Software reaches the block through a small word-addressed register port. It can load either half of the counter, set the alarm, switch counting on and off, arm the interrupt, and clear status flags by writing ones. The counter stops for any of three reasons, and it stays stopped until that reason is removed: it wraps past its largest value, the external `invalid_i` condition is raised, or the count enable is clear. Two lock bits protect the counter halves from being rewritten.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the seconds (address 0) and fraction (address 1) read 0, the alarm (address 2) reads 0xFFFFFFFF, control (address 3) and status (address 4) read 0, and `alarm_irq` is low.
- R2: While control bit 3 (count enable) is 1, `invalid_i` is 0 and the overflow flag is 0, the 47-bit value {seconds, fraction} grows by one per clock; the fraction field is 15 bits wide and carries into seconds.
- R3: With control bit 3 at 0 the counter holds its value, and reads return that frozen value.
- R4: While `invalid_i` is 1 the counter holds its value; it resumes counting on the first clock after `invalid_i` returns to 0.
- R5: An increment from the all-ones count makes the counter read 0 and sets status bit 0 (overflow) on the same clock; the counter then holds at 0 until status bit 0 is cleared.
- R6: When the seconds field equals the alarm value, status bit 1 (alarm) is set on the following clock; an alarm value of all ones never matches.
- R7: `alarm_irq` is high exactly when status bit 1 and control bit 4 (alarm interrupt enable) are both 1.
- R8: Writing the status register clears each flag whose data bit is 1 and leaves flags written with 0 unchanged; a flag whose set condition holds in the same cycle stays set.
- R9: A write to address 0 replaces the seconds field and a write to address 1 replaces the fraction with data bits 14:0; the counter does not advance on the clock of such a write, and bits 31:15 of address 1 read 0.
- R10: Control bit 0 (soft lock) is freely written; control bit 1 (hard lock) is set by writing 1 and stays set until reset; while either is 1, writes to addresses 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timekeeping clock; every cycle is one counter tick |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for `rd_addr`, combinational from register state |
| invalid_i | input | 1 | Not-valid condition; stops the counter while high |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The counter is driven through free running across a fraction-to-seconds carry, then halted in turn by a clear enable, by `invalid_i` and by wrapping, which shows that each stop cause freezes the value and that only its own removal restarts counting. The alarm is exercised with a seconds crossing into a programmed value, with a clear attempted while the match still holds, and with the all-ones value at an all-ones seconds count, which tells a real match apart from the unset encoding. Loads are issued while running, while unlocked, under the soft lock and under the hard lock, which separates load priority over counting from lock blocking.

// File: rtl/rtc_pkg.sv
`timescale 1ns/10ps
package rtc_pkg;
  // register addresses
  localparam int A_SEC  = 0;
  localparam int A_FRAC = 1;
  localparam int A_ALM  = 2;
  localparam int A_CTRL = 3;
  localparam int A_STAT = 4;
  // control bit positions
  localparam int CB_SOFT = 0;
  localparam int CB_HARD = 1;
  localparam int CB_EN   = 3;
  localparam int CB_IE   = 4;
  // status bit positions
  localparam int SB_OVF = 0;
  localparam int SB_ALM = 1;
endpackage

// File: rtl/rtc_time_ctr.sv
`timescale 1ns/10ps
module rtc_time_ctr #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              ld_sec_i,
  input  logic              ld_frac_i,
  input  logic [SEC_W-1:0]  ld_sec_val,
  input  logic [FRAC_W-1:0] ld_frac_val,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              wrap_o
);
  localparam int CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             carry;
  logic             upd;

  // next state: a load wins over counting and suppresses the tick
  always_comb begin
    cnt_d = cnt_q;
    carry = 1'b0;
    if (ld_sec_i || ld_frac_i) begin
      if (ld_sec_i)  cnt_d[CNT_W-1:FRAC_W] = ld_sec_val;
      if (ld_frac_i) cnt_d[FRAC_W-1:0]     = ld_frac_val;
    end else if (run_i) begin
      {carry, cnt_d} = {1'b0, cnt_q} + (CNT_W+1)'(1);
    end
  end

  assign upd = ld_sec_i | ld_frac_i | run_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign sec_o  = cnt_q[CNT_W-1:FRAC_W];
  assign frac_o = cnt_q[FRAC_W-1:0];
  assign wrap_o = carry;
endmodule

// File: rtl/rtc_alarm_unit.sv
`timescale 1ns/10ps
module rtc_alarm_unit #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alm_wr_i,
  input  logic [SEC_W-1:0] alm_val_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             flag_clr_i,
  output logic [SEC_W-1:0] alm_o,
  output logic             flag_o
);
  localparam logic [SEC_W-1:0] UNSET = '1;

  logic [SEC_W-1:0] alm_q;
  logic             flag_q, flag_d;
  logic             hit;

  assign hit = (sec_i == alm_q) && (alm_q != UNSET);

  // set has priority over a write-one clear
  always_comb begin
    flag_d = hit | (flag_q & ~flag_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alm_q <= UNSET;
    else if (alm_wr_i) alm_q <= alm_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign alm_o  = alm_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_ctrl_regs.sv
`timescale 1ns/10ps
module rtc_ctrl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr_i,
  input  logic soft_v,
  input  logic hard_v,
  input  logic en_v,
  input  logic ie_v,
  input  logic ovf_set_i,
  input  logic ovf_clr_i,
  output logic soft_o,
  output logic hard_o,
  output logic en_o,
  output logic ie_o,
  output logic ovf_o
);
  logic soft_q, hard_q, en_q, ie_q, ovf_q;
  logic soft_d, hard_d, en_d, ie_d, ovf_d;

  always_comb begin
    soft_d = ctrl_wr_i ? soft_v : soft_q;
    hard_d = hard_q | (ctrl_wr_i & hard_v);   // sticky until reset
    en_d   = ctrl_wr_i ? en_v : en_q;
    ie_d   = ctrl_wr_i ? ie_v : ie_q;
    ovf_d  = ovf_set_i | (ovf_q & ~ovf_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= 1'b0;
      hard_q <= 1'b0;
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
    end else if (ctrl_wr_i) begin
      soft_q <= soft_d;
      hard_q <= hard_d;
      en_q   <= en_d;
      ie_q   <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign soft_o = soft_q;
  assign hard_o = hard_q;
  assign en_o   = en_q;
  assign ie_o   = ie_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/rtc_sec_alarm.sv
`timescale 1ns/10ps
module rtc_sec_alarm #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              invalid_i,
  output logic              alarm_irq
);
  import rtc_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // write decode
  logic wr_sec, wr_frac, wr_alm, wr_ctrl, wr_stat;
  assign wr_sec  = wr_en && (wr_addr == ADDR_W'(A_SEC));
  assign wr_frac = wr_en && (wr_addr == ADDR_W'(A_FRAC));
  assign wr_alm  = wr_en && (wr_addr == ADDR_W'(A_ALM));
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign wr_stat = wr_en && (wr_addr == ADDR_W'(A_STAT));

  logic              soft_lk, hard_lk, cnt_en, irq_en, ovf_flag, alm_flag;
  logic              locked, run, wrap;
  logic [SEC_W-1:0]  sec_q, alm_q;
  logic [FRAC_W-1:0] frac_q;

  assign locked = soft_lk | hard_lk;
  assign run    = cnt_en & ~invalid_i & ~ovf_flag;

  rtc_time_ctr #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .run_i       (run),
    .ld_sec_i    (wr_sec & ~locked),
    .ld_frac_i   (wr_frac & ~locked),
    .ld_sec_val  (wr_data[SEC_W-1:0]),
    .ld_frac_val (wr_data[FRAC_W-1:0]),
    .sec_o       (sec_q),
    .frac_o      (frac_q),
    .wrap_o      (wrap)
  );

  rtc_alarm_unit #(.SEC_W(SEC_W)) u_alm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .alm_wr_i   (wr_alm),
    .alm_val_i  (wr_data[SEC_W-1:0]),
    .sec_i      (sec_q),
    .flag_clr_i (wr_stat & wr_data[SB_ALM]),
    .alm_o      (alm_q),
    .flag_o     (alm_flag)
  );

  rtc_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl_wr_i (wr_ctrl),
    .soft_v    (wr_data[CB_SOFT]),
    .hard_v    (wr_data[CB_HARD]),
    .en_v      (wr_data[CB_EN]),
    .ie_v      (wr_data[CB_IE]),
    .ovf_set_i (wrap),
    .ovf_clr_i (wr_stat & wr_data[SB_OVF]),
    .soft_o    (soft_lk),
    .hard_o    (hard_lk),
    .en_o      (cnt_en),
    .ie_o      (irq_en),
    .ovf_o     (ovf_flag)
  );

  // read mux
  logic [DATA_W-1:0] ctrl_word, stat_word;
  always_comb begin
    ctrl_word          = '0;
    ctrl_word[CB_SOFT] = soft_lk;
    ctrl_word[CB_HARD] = hard_lk;
    ctrl_word[CB_EN]   = cnt_en;
    ctrl_word[CB_IE]   = irq_en;
    stat_word          = '0;
    stat_word[SB_OVF]  = ovf_flag;
    stat_word[SB_ALM]  = alm_flag;
  end

  always_comb begin
    case (rd_addr)
      ADDR_W'(A_SEC):  rd_data = DATA_W'(sec_q);
      ADDR_W'(A_FRAC): rd_data = DATA_W'(frac_q);
      ADDR_W'(A_ALM):  rd_data = DATA_W'(alm_q);
      ADDR_W'(A_CTRL): rd_data = ctrl_word;
      ADDR_W'(A_STAT): rd_data = stat_word;
      default:         rd_data = '0;
    endcase
  end

  assign alarm_irq = alm_flag & irq_en;
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
`timescale 1ns/10ps
module rtc_sec_alarm_chk #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              invalid_i,
  input logic [SEC_W-1:0]  sec,
  input logic [FRAC_W-1:0] frac,
  input logic [SEC_W-1:0]  alm,
  input logic              alm_flag,
  input logic              ovf,
  input logic              cnt_en
);
  localparam int CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] cnt;
  logic             ld, run;
  assign cnt = {sec, frac};
  assign ld  = wr_en && (wr_addr == ADDR_W'(0) || wr_addr == ADDR_W'(1));
  assign run = cnt_en && !invalid_i && !ovf;

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld && !(&cnt)) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // covers R3 and R4
  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt));

  a_r5_wrap_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld && (&cnt)) |=> (ovf && cnt == '0));

  a_r6_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((sec == alm) && !(&alm)) |=> alm_flag);

  a_r6_unset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((&alm) && !alm_flag) |=> !alm_flag);
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk #(
  .SEC_W(SEC_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .invalid_i (invalid_i),
  .sec       (sec_q),
  .frac      (frac_q),
  .alm       (alm_q),
  .alm_flag  (alm_flag),
  .ovf       (ovf_flag),
  .cnt_en    (cnt_en)
);

// File: tb/sim_rtc_sec_alarm.sv
`timescale 1ns/10ps
module sim_rtc_sec_alarm;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        invalid_i;
  logic        alarm_irq;

  always #2 clk = ~clk;   // 250 MHz

  rtc_sec_alarm u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .invalid_i(invalid_i), .alarm_irq(alarm_irq)
  );

  typedef struct {
    bit          is_irq;
    logic [2:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    n_pend = 0;
  int    total  = 0;
  int    bad    = 0;
  bit    done   = 0;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      logic [31:0] got;
      wait (n_pend > 0);
      rd_addr = exp_q[0].addr;
      #0.1;
      got = exp_q[0].is_irq ? {31'd0, alarm_irq} : rd_data;
      total++;
      if (got !== exp_q[0].exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", exp_q[0].tag, got, exp_q[0].exp);
      end
      void'(exp_q.pop_front());
      n_pend--;
    end
  end

  // driver side: push an expected item and wait for the monitor
  task automatic chk(input bit irq, input int addr, input logic [31:0] exp, input string tag);
    item_t it;
    it.is_irq = irq;
    it.addr   = addr[2:0];
    it.exp    = exp;
    it.tag    = tag;
    exp_q.push_back(it);
    n_pend++;
    wait (n_pend == 0);
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = addr[2:0];
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; invalid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(0, 0, 32'h0, "R1 seconds");
    chk(0, 1, 32'h0, "R1 fraction");
    chk(0, 2, 32'hFFFF_FFFF, "R1 alarm");
    chk(0, 3, 32'h0, "R1 control");
    chk(0, 4, 32'h0, "R1 status");
    chk(1, 0, 32'h0, "R1 irq");

    // R9 loads while stopped, upper fraction bits dropped
    wr(0, 32'd100);
    wr(1, 32'hABCD_0005);
    chk(0, 0, 32'd100, "R9 seconds load");
    chk(0, 1, 32'd5, "R9 fraction load");

    // R2 counting
    wr(3, 32'h08);
    repeat (10) @(negedge clk);
    chk(0, 1, 32'd15, "R2 ten ticks");
    chk(0, 0, 32'd100, "R2 seconds steady");

    // R3 enable clear freezes
    wr(3, 32'h00);
    repeat (5) @(negedge clk);
    chk(0, 1, 32'd17, "R3 frozen");

    // R9 load wins over counting, R2 carry
    wr(3, 32'h08);
    wr(1, 32'h7FFE);
    chk(0, 1, 32'h7FFE, "R9 load while running");
    repeat (2) @(negedge clk);
    chk(0, 0, 32'd101, "R2 carry seconds");
    chk(0, 1, 32'd0, "R2 carry fraction");

    // R4 invalid stops, resumes
    invalid_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(0, 1, 32'd0, "R4 held fraction");
    chk(0, 0, 32'd101, "R4 held seconds");
    invalid_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(0, 1, 32'd3, "R4 resumed");

    // R6 alarm, R7 irq, R8 clear rules
    wr(2, 32'd102);
    wr(1, 32'h7FFD);
    chk(0, 4, 32'h0, "R6 no early match");
    repeat (3) @(negedge clk);
    chk(0, 0, 32'd102, "R6 seconds reach alarm");
    chk(0, 4, 32'h0, "R6 flag one clock later");
    @(negedge clk);
    chk(0, 4, 32'h2, "R6 flag set");
    chk(1, 0, 32'h0, "R7 irq masked");
    wr(3, 32'h18);
    chk(1, 0, 32'h1, "R7 irq raised");
    wr(4, 32'h2);
    chk(0, 4, 32'h2, "R8 set wins over clear");
    wr(2, 32'd500);
    wr(4, 32'h1);
    chk(0, 4, 32'h2, "R8 zero bit leaves flag");
    wr(4, 32'h2);
    chk(0, 4, 32'h0, "R8 flag cleared");
    chk(1, 0, 32'h0, "R7 irq dropped");

    // R6 unset value, R5 overflow
    wr(2, 32'hFFFF_FFFF);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'h7FFC);
    repeat (3) @(negedge clk);
    chk(0, 0, 32'hFFFF_FFFF, "R6 seconds all ones");
    chk(0, 4, 32'h0, "R6 unset never matches");
    @(negedge clk);
    chk(0, 0, 32'h0, "R5 wrapped seconds");
    chk(0, 1, 32'h0, "R5 wrapped fraction");
    chk(0, 4, 32'h1, "R5 overflow flag");
    repeat (5) @(negedge clk);
    chk(0, 1, 32'h0, "R5 held after wrap");
    wr(4, 32'h1);
    chk(0, 4, 32'h0, "R5 overflow cleared");
    chk(0, 1, 32'h0, "R5 still zero at clear");
    repeat (2) @(negedge clk);
    chk(0, 1, 32'd2, "R5 resumed");

    // R10 locks
    wr(3, 32'h01);
    wr(0, 32'd55);
    chk(0, 0, 32'h0, "R10 soft lock blocks seconds");
    chk(0, 1, 32'd4, "R10 counter untouched");
    chk(0, 3, 32'h1, "R10 soft lock set");
    wr(3, 32'h00);
    chk(0, 3, 32'h0, "R10 soft lock cleared");
    wr(0, 32'd55);
    chk(0, 0, 32'd55, "R10 unlocked load");
    wr(3, 32'h02);
    wr(3, 32'h00);
    chk(0, 3, 32'h2, "R10 hard lock sticky");
    wr(0, 32'd7);
    wr(1, 32'd9);
    chk(0, 0, 32'd55, "R10 hard lock blocks seconds");
    chk(0, 1, 32'd4, "R10 hard lock blocks fraction");

    done = 1;
    finish_run();
  end
endmodule